// File: doc/BRIEF.md
# Serial Wire Debug Target Packet Responder

This block is the target end of a two-wire serial debug link. It runs on a local system clock that is much faster than the debug clock. The incoming debug clock and data line pass through a synchronizer, and rising edges of the debug clock are found by comparing two samples. On those edges it collects 8-bit request headers from the host and answers valid ones with a 3-bit acknowledge. For reads it then shifts out a word from a small internal register bank. For writes it takes in a word and stores it there. The block drives the shared data line only through a data output and an output-enable, and an external pad joins them with the host's driver.

Register storage is two ports of four words each. The port is chosen by a header bit and the word by two address bits. A busy input makes the target answer WAIT. An even-parity error on host write data is held as a sticky fault, and the next packets are refused with FAULT until the host sends a line reset: a long run of high bits on the data line.

In the requirements, edge N is the N-th rising debug-clock edge after the edge that samples a request's park bit (edge 0). DATA_W is 32 by default.

Top module: `swd_target_resp`

## Requirements
- R1: Host bits are sampled only on rising debug-clock edges, and the output and output-enable change only in response to such an edge. The line is not driven on the edge that samples the park bit, so the first turnaround is half a debug-clock cycle.
- R2: A header is read in the order start, port, rnw, A2, A3, parity, stop, park. It is accepted only when start=1, stop=0, park=1 and port^rnw^A2^A3^parity is 0. A rejected header gets no drive at all, and the target waits for the next high bit.
- R3: For an accepted header the acknowledge is driven on edges 1, 2 and 3, bit 0 first. The codes are OK=001, WAIT=010 and FAULT=100.
- R4: A read with OK drives the selected word LSB first on edges 4 to 35. It drives the even parity of the word (the XOR of its bits) on edge 36 and releases the line on edge 37.
- R5: A write with OK releases the line on edge 4 and ignores edge 5. Data bits are sampled LSB first on edges 6 to 37 and the parity bit on edge 38. When the word XORed with the parity bit is 0, the word is stored.
- R6: The register index is port*4 + A3*2 + A2. A read returns the last word stored at that index.
- R7: With busy high at the park edge, a read answers WAIT and releases the line on edge 4 without driving data. A write answers WAIT, accepts the data phase of R5, and neither stores the data nor checks its parity.
- R8: A write parity error stores nothing and sets a sticky fault. While the fault is set, every accepted request answers FAULT (this overrides busy) and the line is released on edge 4 with no data phase.
- R9: 50 consecutive rising edges that sample the line high while the target is not driving cause a line reset. The reset aborts any packet and clears the fault. The target then ignores the line until it samples a low bit. 49 such edges have no effect.
- R10: After reset the line is released, no fault is set and all eight words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_clk_i | input | 1 | Debug clock from the host |
| dbg_dio_i | input | 1 | Level of the shared data line |
| busy_i | input | 1 | Makes accepted requests answer WAIT |
| dbg_dio_o | output | 1 | Value the target drives onto the data line |
| dbg_dio_oe_o | output | 1 | High while the target drives the data line |

## Verification
The hardest state to reach from the ports is the sticky fault and its removal. Only a write whose parity bit has been deliberately corrupted can set it, and only an exact run of high host bits can clear it. While the line is high, those bits are also parsed as request headers. The bench therefore sets the fault with a flipped-parity write and shows that a run of 49 highs leaves the fault in place, since the highs are only parsed as rejected headers. It then shows that a run of 50 clears it. To show the lockout, it sends a valid header straight after the run, with no low bit in between, and checks that the target never drives.

// File: rtl/swd_resp_pkg.sv
`timescale 1ns/1ps
package swd_resp_pkg;

   typedef enum logic [2:0] {
      ACK_OK    = 3'b001,
      ACK_WAIT  = 3'b010,
      ACK_FAULT = 3'b100
   } ack_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_ACK,
      ST_RDATA,
      ST_RTRN,
      ST_WTRN,
      ST_WDATA,
      ST_LOCK
   } st_e;

   typedef struct packed {
      logic       port;
      logic       rnw;
      logic [1:0] addr;
   } req_t;

   // header bits: [0] start [1] port [2] rnw [3] A2 [4] A3 [5] parity [6] stop [7] park
   function automatic logic hdr_good(input logic [7:0] h);
      return h[0] & ~h[6] & h[7] & ~(^h[5:1]);
   endfunction

endpackage

// File: rtl/swd_edge_sync.sv
`timescale 1ns/1ps
module swd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdio_i,
   output logic rise_o,
   output logic bit_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("swd_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ck_sh;
   logic [STAGES-1:0] dt_sh;
   logic              ck_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_sh   <= '0;
         dt_sh   <= '0;
         ck_last <= 1'b0;
      end else begin
         ck_sh   <= {ck_sh[STAGES-2:0], sclk_i};
         dt_sh   <= {dt_sh[STAGES-2:0], sdio_i};
         ck_last <= ck_sh[STAGES-1];
      end
   end

   assign rise_o = ck_sh[STAGES-1] & ~ck_last;
   assign bit_o  = dt_sh[STAGES-1];

   // R1: an edge is reported for exactly one system cycle
   a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/swd_linereset_det.sv
`timescale 1ns/1ps
module swd_linereset_det #(
   parameter int LEN = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic bit_i,
   input  logic drv_i,
   output logic hit_o
);

   localparam int CW = $clog2(LEN + 1);

   if (LEN < 9) begin : g_bad_len
      $error("swd_linereset_det: LEN must exceed one header");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (rise_i) begin
         if (drv_i || !bit_i)
            run_q <= '0;
         else if (run_q != CW'(LEN))
            run_q <= run_q + 1'b1;
      end
   end

   assign hit_o = rise_i & ~drv_i & bit_i & (run_q == CW'(LEN - 1));

   // R9: a reset is only ever triggered by a high bit sampled from the host
   a_r9_hit_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (rise_i && bit_i && !drv_i));

endmodule

// File: rtl/swd_reg_bank.sv
`timescale 1ns/1ps
module swd_reg_bank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << IDX_W;

   if (DEPTH > 64) begin : g_bad_depth
      $error("swd_reg_bank: bank too deep");
   end

   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we_i && (widx_i == IDX_W'(g)))
            q <= wdata_i;
      end
      assign cell_q[g] = q;
   end

   assign rdata_o = cell_q[ridx_i];

endmodule

// File: rtl/swd_target_resp.sv
`timescale 1ns/1ps
module swd_target_resp
   import swd_resp_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int RESET_LEN   = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dbg_clk_i,
   input  logic dbg_dio_i,
   input  logic busy_i,
   output logic dbg_dio_o,
   output logic dbg_dio_oe_o
);

   localparam int IDX_W = 3;
   localparam int CNT_W = $clog2(DATA_W + 1) + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("swd_target_resp: DATA_W must be positive");
   end

   logic              rise;
   logic              din;
   logic              lr_hit;
   st_e               st;
   logic [CNT_W-1:0]  cnt;
   logic [6:0]        hdr_sh;
   logic [7:0]        hdr_full;
   req_t              req_q;
   ack_e              ack_q;
   ack_e              ack_sel;
   logic [DATA_W-1:0] sh_q;
   logic              par_q;
   logic              fault_q;
   logic              oe_q;
   logic              dout_q;
   logic [IDX_W-1:0]  rd_idx;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] rd_word;
   logic              we;
   logic              last_bit;
   st_e               after_ack;

   swd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (dbg_clk_i),
      .sdio_i (dbg_dio_i),
      .rise_o (rise),
      .bit_o  (din)
   );

   swd_linereset_det #(.LEN(RESET_LEN)) u_lrst (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (rise),
      .bit_i  (din),
      .drv_i  (oe_q),
      .hit_o  (lr_hit)
   );

   swd_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .widx_i  (wr_idx),
      .wdata_i (sh_q),
      .ridx_i  (rd_idx),
      .rdata_o (rd_word)
   );

   assign hdr_full = {din, hdr_sh};
   assign rd_idx   = {hdr_full[1], hdr_full[4], hdr_full[3]};
   assign wr_idx   = {req_q.port, req_q.addr};
   assign last_bit = (cnt == CNT_W'(DATA_W));

   always_comb begin
      if (fault_q)     ack_sel = ACK_FAULT;
      else if (busy_i) ack_sel = ACK_WAIT;
      else             ack_sel = ACK_OK;
   end

   always_comb begin
      if (ack_q == ACK_OK && req_q.rnw)        after_ack = ST_RDATA;
      else if (!req_q.rnw && ack_q != ACK_FAULT) after_ack = ST_WTRN;
      else                                     after_ack = ST_RTRN;
   end

   assign we = rise & ~lr_hit & (st == ST_WDATA) & last_bit
             & (ack_q == ACK_OK) & ~(par_q ^ din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         hdr_sh  <= '0;
         req_q   <= '0;
         ack_q   <= ACK_OK;
         sh_q    <= '0;
         par_q   <= 1'b0;
         fault_q <= 1'b0;
         oe_q    <= 1'b0;
         dout_q  <= 1'b0;
      end else if (lr_hit) begin
         st      <= ST_LOCK;
         fault_q <= 1'b0;
         oe_q    <= 1'b0;
         dout_q  <= 1'b0;
      end else if (rise) begin
         case (st)
            ST_IDLE: begin
               if (din) begin
                  hdr_sh <= 7'b100_0000;
                  cnt    <= CNT_W'(1);
                  st     <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (cnt == CNT_W'(7)) begin
                  cnt <= '0;
                  if (hdr_good(hdr_full)) begin
                     req_q.port <= hdr_full[1];
                     req_q.rnw  <= hdr_full[2];
                     req_q.addr <= {hdr_full[4], hdr_full[3]};
                     ack_q      <= ack_sel;
                     sh_q       <= rd_word;
                     par_q      <= ^rd_word;
                     st         <= ST_ACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  hdr_sh <= {din, hdr_sh[6:1]};
                  cnt    <= cnt + 1'b1;
               end
            end
            ST_ACK: begin
               oe_q   <= 1'b1;
               dout_q <= ack_q[cnt[1:0]];
               if (cnt == CNT_W'(2)) begin
                  cnt <= '0;
                  st  <= after_ack;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RDATA: begin
               if (last_bit) begin
                  dout_q <= par_q;
                  cnt    <= '0;
                  st     <= ST_RTRN;
               end else begin
                  dout_q <= sh_q[0];
                  sh_q   <= sh_q >> 1;
                  cnt    <= cnt + 1'b1;
               end
            end
            ST_RTRN: begin
               oe_q   <= 1'b0;
               dout_q <= 1'b0;
               st     <= ST_IDLE;
            end
            ST_WTRN: begin
               oe_q   <= 1'b0;
               dout_q <= 1'b0;
               if (cnt == CNT_W'(1)) begin
                  cnt   <= '0;
                  par_q <= 1'b0;
                  st    <= ST_WDATA;
               end else begin
                  cnt <= CNT_W'(1);
               end
            end
            ST_WDATA: begin
               if (last_bit) begin
                  cnt <= '0;
                  st  <= ST_IDLE;
                  if (ack_q == ACK_OK && (par_q ^ din))
                     fault_q <= 1'b1;
               end else begin
                  sh_q  <= {din, sh_q[DATA_W-1:1]};
                  par_q <= par_q ^ din;
                  cnt   <= cnt + 1'b1;
               end
            end
            ST_LOCK: begin
               if (!din) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign dbg_dio_o    = dout_q;
   assign dbg_dio_oe_o = oe_q;

   // R1: the enable only moves on a detected debug-clock rising edge
   a_r1_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> $past(rise));

   // R1: the driven value only moves on a detected rising edge
   a_r1_dout_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_q != $past(dout_q)) |-> $past(rise));

   // R3: an acknowledge in flight is always one legal code
   a_r3_ack_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK) |-> ($countones(ack_q) == 1));

   // R7 / R8: the bank is written only after an OK acknowledge
   a_r7_store_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (ack_q == ACK_OK && !fault_q));

   // R8: read data are only shifted out after OK
   a_r8_data_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDATA) |-> (ack_q == ACK_OK));

   // R9: a line reset leaves the target idle-locked, released and fault-free
   a_r9_lock_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      lr_hit |=> (st == ST_LOCK && !fault_q && !oe_q));

endmodule

// File: tb/sim_swd_target_resp.sv
`timescale 1ns/1ps
module sim_swd_target_resp;

   localparam int HALF = 8;
   localparam logic [2:0] K_OK    = 3'b001;
   localparam logic [2:0] K_WAIT  = 3'b010;
   localparam logic [2:0] K_FAULT = 3'b100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dbg_clk = 1'b0;
   logic host_val = 1'b0;
   logic host_en = 1'b1;
   logic busy = 1'b0;
   logic dio_o;
   logic dio_oe;
   logic bus_w;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] exp_bank [8];
   logic s_l, s_o;

   assign bus_w = dio_oe ? dio_o : (host_en ? host_val : 1'b1);

   always #10 clk = ~clk;

   swd_target_resp u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .dbg_clk_i    (dbg_clk),
      .dbg_dio_i    (bus_w),
      .busy_i       (busy),
      .dbg_dio_o    (dio_o),
      .dbg_dio_oe_o (dio_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // one debug-clock bit: falling half (host drives, line observed at its end), then rising half
   task automatic cyc(input logic hv, input logic hen, output logic sl, output logic so);
      @(negedge clk);
      dbg_clk = 1'b0; host_val = hv; host_en = hen;
      repeat (HALF - 1) @(negedge clk);
      sl = bus_w; so = dio_oe;
      @(negedge clk);
      dbg_clk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
   endtask

   task automatic idle(input int n);
      logic a, b;
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, a, b);
   endtask

   task automatic ones(input int n);
      logic a, b;
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, a, b);
   endtask

   task automatic send_header(input logic port, input logic rnw, input logic [1:0] addr, input int bad);
      logic [7:0] h;
      logic a, b;
      h[0] = 1'b1; h[1] = port; h[2] = rnw; h[3] = addr[0]; h[4] = addr[1];
      h[5] = port ^ rnw ^ addr[0] ^ addr[1]; h[6] = 1'b0; h[7] = 1'b1;
      if (bad == 1) h[5] = ~h[5];
      if (bad == 2) h[6] = 1'b1;
      if (bad == 3) h[7] = 1'b0;
      for (int i = 0; i < 8; i++) cyc(h[i], 1'b1, a, b);
   endtask

   task automatic get_ack(output logic [2:0] a);
      logic sl, so;
      bit drv;
      cyc(1'b0, 1'b0, sl, so);
      chk(!so, "R1 half-cycle turnaround", {63'd0, so}, 64'd0);
      drv = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b0, sl, so);
         a[i] = sl;
         if (!so) drv = 1'b0;
      end
      chk(drv, "R3 ack driven on edges 1..3", {63'd0, drv}, 64'd1);
   endtask

   task automatic do_read(input logic port, input logic [1:0] addr, input logic [2:0] ea,
                          input logic [31:0] ed, input string tag);
      logic [2:0] a;
      logic [31:0] d;
      logic p, sl, so;
      bit drv;
      send_header(port, 1'b1, addr, 0);
      get_ack(a);
      chk(a == ea, tag, {61'd0, a}, {61'd0, ea});
      if (ea == K_OK) begin
         drv = 1'b1;
         for (int i = 0; i < 32; i++) begin
            cyc(1'b0, 1'b0, sl, so);
            d[i] = sl;
            if (!so) drv = 1'b0;
         end
         cyc(1'b0, 1'b0, p, so);
         chk(drv && so, "R1 read data driven", {63'd0, drv}, 64'd1);
         chk(d == ed, tag, {32'd0, d}, {32'd0, ed});
         chk(p == ^ed, "R4 read parity", {63'd0, p}, {63'd0, ^ed});
         cyc(1'b0, 1'b1, sl, so);
         chk(!so, "R4 release on edge 37", {63'd0, so}, 64'd0);
      end else begin
         cyc(1'b0, 1'b1, sl, so);
         chk(!so, "R7 R8 no read data phase", {63'd0, so}, 64'd0);
      end
      idle(2);
   endtask

   task automatic do_write(input logic port, input logic [1:0] addr, input logic [31:0] wd,
                           input logic flip, input logic [2:0] ea, input string tag);
      logic [2:0] a;
      logic sl, so;
      send_header(port, 1'b0, addr, 0);
      get_ack(a);
      chk(a == ea, tag, {61'd0, a}, {61'd0, ea});
      if (ea == K_FAULT) begin
         cyc(1'b0, 1'b1, sl, so);
         chk(!so, "R8 no write data phase", {63'd0, so}, 64'd0);
      end else begin
         cyc(1'b0, 1'b0, sl, so);
         chk(!so, "R5 released on edge 4", {63'd0, so}, 64'd0);
         for (int i = 0; i < 32; i++) cyc(wd[i], 1'b1, sl, so);
         cyc((^wd) ^ flip, 1'b1, sl, so);
      end
      idle(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10: released after reset
      chk(!dio_oe, "R10 released after reset", {63'd0, dio_oe}, 64'd0);
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 1'b1, s_l, s_o);
         chk(!s_o, "R10 idle no drive", {63'd0, s_o}, 64'd0);
      end

      // R10 R6: every word reads zero
      for (int i = 0; i < 8; i++) begin
         exp_bank[i] = 32'd0;
         do_read(i[2], i[1:0], K_OK, 32'd0, "R10 zero after reset");
      end

      // R5 R6: fill the bank with distinct words, then read back in reverse order
      for (int i = 0; i < 8; i++) begin
         exp_bank[i] = (32'h9E37_79B9 * (i + 1)) ^ (32'h1 << (i * 4));
         do_write(i[2], i[1:0], exp_bank[i], 1'b0, K_OK, "R5 write ack OK");
      end
      for (int i = 7; i >= 0; i--)
         do_read(i[2], i[1:0], K_OK, exp_bank[i], "R6 read back index");

      // R2: each header corruption, both directions, gets no drive
      for (int bad = 1; bad <= 3; bad++) begin
         for (int rw = 0; rw < 2; rw++) begin
            send_header(1'b1, rw[0], 2'b10, bad);
            for (int k = 0; k < 6; k++) begin
               cyc(1'b0, 1'b1, s_l, s_o);
               chk(!s_o, "R2 rejected header not answered", {63'd0, s_o}, 64'd0);
            end
         end
      end
      do_read(1'b0, 2'b01, K_OK, exp_bank[1], "R2 accepted after rejects");

      // R7: busy answers WAIT; write data discarded and its bad parity ignored
      busy = 1'b1;
      do_read(1'b0, 2'b10, K_WAIT, 32'd0, "R7 busy read WAIT");
      do_write(1'b0, 2'b10, ~exp_bank[2], 1'b1, K_WAIT, "R7 busy write WAIT");
      busy = 1'b0;
      do_read(1'b0, 2'b10, K_OK, exp_bank[2], "R7 busy write discarded");

      // R8: parity error then FAULT, over busy, writes blocked
      do_write(1'b1, 2'b01, 32'hDEAD_0001, 1'b1, K_OK, "R8 bad parity write acked");
      do_read(1'b1, 2'b01, K_FAULT, 32'd0, "R8 next packet FAULT");
      busy = 1'b1;
      do_read(1'b0, 2'b00, K_FAULT, 32'd0, "R8 FAULT overrides busy");
      busy = 1'b0;
      do_write(1'b0, 2'b11, 32'h0BAD_F00D, 1'b0, K_FAULT, "R8 write refused");

      // R9: 49 highs are not enough
      ones(49);
      idle(10);
      do_read(1'b1, 2'b01, K_FAULT, 32'd0, "R9 49 highs keep fault");

      // R9: 50 highs clear the fault; the bad write never landed
      ones(50);
      idle(2);
      do_read(1'b1, 2'b01, K_OK, exp_bank[5], "R9 fault cleared by 50 highs");
      do_read(1'b0, 2'b11, K_OK, exp_bank[3], "R8 refused write not stored");

      // R9: a header right after the run, with no low in between, is ignored
      ones(50);
      send_header(1'b0, 1'b1, 2'b00, 0);
      for (int k = 0; k < 10; k++) begin
         cyc(1'b0, 1'b1, s_l, s_o);
         chk(!s_o, "R9 lockout ignores header", {63'd0, s_o}, 64'd0);
      end
      do_read(1'b0, 2'b00, K_OK, exp_bank[0], "R9 normal after low bit");

      // R5: storing works again after recovery
      exp_bank[5] = 32'hA5A5_5A5A;
      do_write(1'b1, 2'b01, exp_bank[5], 1'b0, K_OK, "R5 write after recovery");
      do_read(1'b1, 2'b01, K_OK, exp_bank[5], "R5 stored word");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule